// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single read or write requests from an internal master into cycles on an external bus. Address and data can share one set of pins (multiplexed) or use separate pins (non-multiplexed). The block drives an address strobe with selectable polarity, a read strobe, write strobes and two byte-lane enables. It inserts a coded number of automatic wait cycles, and it can stretch the strobe phase further with an external ready input. One bus cycle equals one `clk` cycle.

The chip-select decoder presents the configuration of the addressed area together with each request. The block captures it when the request is accepted. That configuration covers data width (8 or 16 bits), byte order, write-strobe style, address-strobe scheme, address-phase extension and wait code. Mode, polarity, ready enable and the per-strobe enables are static inputs. Pad direction is given by `ad_oe`.

Top module: `xbus_seq`

## Requirements
- R1: A request is accepted only while idle and while `ack` is low. `ack` is a single-cycle pulse in the cycle after the last bus cycle of the access, and the block is idle during that pulse.
- R2: Wait code 0..7 adds 0, 1, 2, 3, 4, 8, 16 or 32 setup cycles to the data phase.
- R3: In multiplexed mode the address phase lasts 1 cycle, or 2 when extension is set. During that phase `ad_oe`=1 and `ad_out` carries the cycle address bits 15:0. The data phase follows with at least 2 cycles, so read data is sampled 3 (or 4) cycles after the address appears. Non-multiplexed mode has no address phase, and data is sampled after 2 cycles. `a_out` carries the cycle address for the whole access and is 0 when idle.
- R4: The address strobe is asserted in the first cycle of the address-valid time when `area_as_full`=0, and for the whole of it when `area_as_full`=1. In multiplexed mode that time is the address phase. In non-multiplexed mode it is the data phase. With `as_high`=1 the strobe is active high; with `as_high`=0 it is active low.
- R5: For reads, `rd_n` is low for the whole data phase, and the AD pins are released (`ad_oe`=0, `ad_out`=0).
- R6: For writes, data is driven on `ad_out` from the first data cycle. The write strobe goes low only after the setup and wait cycles.
- R7: With `rdy_en`=1, the strobe cycle repeats while `rdy_i`=0. With `rdy_en`=0, `rdy_i` has no effect.
- R8: On a 16-bit area, a word access (even address) enables both lanes. Little endian maps the word unchanged to AD[15:0]; big endian swaps its bytes. A byte access uses AD[7:0] with `lb_n` for an even address and AD[15:8] with `ub_n` for an odd one. Byte data travels in bits 7:0 of `wdata`/`rdata`, and upper `rdata` bits read 0.
- R9: On an 8-bit area, a word request becomes two byte cycles, at the even address and then the odd address, on AD[7:0] with only `lb_n` active. The first cycle carries the low byte in little endian and the high byte in big endian.
- R10: With `area_wrx`=0, `wrl_n` strobes the lower lane and `wrh_n` strobes the upper lane. With `area_wrx`=1, `wrl_n` strobes every write and `wrh_n` stays high.
- R11: When a strobe's enable input is 0, that output is held at its inactive level.
- R12: After reset the block is idle: strobes inactive, `ad_oe`=0, `ack`=0, `ad_out`=0, `a_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until `ack` |
| we | input | 1 | 1 = write, 0 = read |
| size16 | input | 1 | 1 = word access, 0 = byte access |
| addr | input | ADDR_W | Byte address |
| wdata | input | 16 | Write data |
| ack | output | 1 | Access done pulse |
| rdata | output | 16 | Read data, valid with `ack` |
| area_bw8 | input | 1 | Area data width: 1 = 8 bits |
| area_big | input | 1 | Area byte order: 1 = big endian |
| area_wrx | input | 1 | 1 = single write strobe on `wrl_n` |
| area_as_full | input | 1 | Address strobe over whole address time |
| area_ace | input | 1 | One-cycle address phase extension |
| area_wait | input | 3 | Automatic wait code |
| nonmux | input | 1 | 1 = separate address pins |
| as_high | input | 1 | Address strobe polarity, 1 = active high |
| rdy_en | input | 1 | External ready enable |
| rdy_i | input | 1 | External ready, 1 = ready |
| en_as | input | 1 | Address strobe output enable |
| en_rd | input | 1 | Read strobe output enable |
| en_wrl | input | 1 | Lower write strobe output enable |
| en_wrh | input | 1 | Upper write strobe output enable |
| en_ub | input | 1 | Upper byte enable output enable |
| en_lb | input | 1 | Lower byte enable output enable |
| ad_in | input | 16 | AD pins, input side |
| ad_out | output | 16 | AD pins, output side |
| ad_oe | output | 1 | AD pins output enable |
| a_out | output | ADDR_W | Address pins |
| as_o | output | 1 | Address strobe |
| rd_n | output | 1 | Read strobe, active low |
| wrl_n | output | 1 | Lower or single write strobe, active low |
| wrh_n | output | 1 | Upper write strobe, active low |
| ub_n | output | 1 | Upper byte enable, active low |
| lb_n | output | 1 | Lower byte enable, active low |

## Verification
The assertions assume that the master holds `req` and its fields steady until it sees `ack`. They also assume that the mode, polarity and strobe-enable inputs do not change in the middle of an access; otherwise a write strobe could appear without the preceding data-setup cycle. Word requests are assumed to use even addresses. The stimulus meets these assumptions by changing configuration only between accesses, while the block is idle, and by dropping `req` in the `ack` cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int WAIT_MAX = 32;
  localparam int CNT_W    = $clog2(WAIT_MAX + 2);
  localparam int DATA_W   = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_ADR, ST_DAT} xbus_st_e;

  typedef struct packed {
    logic       bw8;
    logic       big;
    logic       wrx;
    logic       as_full;
    logic       ace;
    logic [2:0] wcode;
  } xbus_area_t;
endpackage

// File: rtl/xbus_wait_dec.sv
module xbus_wait_dec #(
  parameter int CW = 6
) (
  input  logic [2:0]    code,
  output logic [CW-1:0] cycles
);
  // codes 0..4 map linearly, 5..7 are powers of two
  always_comb begin
    if (code < 3'd5) cycles = CW'(code);
    else             cycles = CW'(1) << (code - 3'd2);
  end
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane #(
  parameter int DW = 16
) (
  input  logic          bw8,
  input  logic          big,
  input  logic          wrx,
  input  logic          sz16,
  input  logic          a0,
  input  logic          half,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ad_in,
  input  logic [DW-1:0] rd_old,
  output logic          lo_act,
  output logic          hi_act,
  output logic          wr_lo,
  output logic          wr_hi,
  output logic [DW-1:0] wbus,
  output logic [DW-1:0] rmerge
);
  localparam int BW = DW / 2;
  logic hi_slot;

  assign hi_slot = half ^ big;
  assign lo_act  = bw8 | sz16 | ~a0;
  assign hi_act  = ~bw8 & (sz16 | a0);
  assign wr_lo   = wrx | lo_act;
  assign wr_hi   = ~wrx & hi_act;

  always_comb begin
    if (bw8) begin
      wbus = {{BW{1'b0}}, (sz16 && hi_slot) ? wdata[DW-1:BW] : wdata[BW-1:0]};
      if (!sz16)        rmerge = {{BW{1'b0}}, ad_in[BW-1:0]};
      else if (hi_slot) rmerge = {ad_in[BW-1:0], rd_old[BW-1:0]};
      else              rmerge = {rd_old[DW-1:BW], ad_in[BW-1:0]};
    end else if (sz16) begin
      wbus   = big ? {wdata[BW-1:0], wdata[DW-1:BW]} : wdata;
      rmerge = big ? {ad_in[BW-1:0], ad_in[DW-1:BW]} : ad_in;
    end else begin
      wbus   = a0 ? {wdata[BW-1:0], {BW{1'b0}}} : {{BW{1'b0}}, wdata[BW-1:0]};
      rmerge = {{BW{1'b0}}, a0 ? ad_in[DW-1:BW] : ad_in[BW-1:0]};
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              size16,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic              ack,
  output logic [15:0]       rdata,
  input  logic              area_bw8,
  input  logic              area_big,
  input  logic              area_wrx,
  input  logic              area_as_full,
  input  logic              area_ace,
  input  logic [2:0]        area_wait,
  input  logic              nonmux,
  input  logic              as_high,
  input  logic              rdy_en,
  input  logic              rdy_i,
  input  logic              en_as,
  input  logic              en_rd,
  input  logic              en_wrl,
  input  logic              en_wrh,
  input  logic              en_ub,
  input  logic              en_lb,
  input  logic [15:0]       ad_in,
  output logic [15:0]       ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] a_out,
  output logic              as_o,
  output logic              rd_n,
  output logic              wrl_n,
  output logic              wrh_n,
  output logic              ub_n,
  output logic              lb_n
);
  xbus_st_e           st, st_n;
  logic [CNT_W-1:0]   cnt, cnt_n, wcyc;
  logic               half, half_n, we_q, we_n, sz_q, sz_n, ack_q, ack_n;
  xbus_area_t         area_q, area_n;
  logic [ADDR_W-1:0]  addr_q, addr_n, cyc_addr;
  logic [DATA_W-1:0]  wd_q, wd_n, rdata_q, rdata_n, wbus, rmerge;
  logic               lo_act, hi_act, wr_lo, wr_hi;
  logic               busy, strobe_ph, fin, split, as_act;

  xbus_wait_dec #(.CW(CNT_W)) u_wdec (.code(area_q.wcode), .cycles(wcyc));

  xbus_lane #(.DW(DATA_W)) u_lane (
    .bw8(area_q.bw8), .big(area_q.big), .wrx(area_q.wrx), .sz16(sz_q),
    .a0(addr_q[0]), .half(half), .wdata(wd_q), .ad_in(ad_in), .rd_old(rdata_q),
    .lo_act(lo_act), .hi_act(hi_act), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wbus(wbus), .rmerge(rmerge)
  );

  assign busy      = (st != ST_IDLE);
  assign split     = area_q.bw8 & sz_q;
  assign strobe_ph = (st == ST_DAT) && (cnt > wcyc);
  assign fin       = strobe_ph && (!rdy_en || rdy_i);

  always_comb begin
    if (split)     cyc_addr = {addr_q[ADDR_W-1:1], half};
    else if (sz_q) cyc_addr = {addr_q[ADDR_W-1:1], 1'b0};
    else           cyc_addr = addr_q;
  end

  // next-state process
  always_comb begin
    st_n = st; cnt_n = cnt; half_n = half; area_n = area_q; we_n = we_q;
    sz_n = sz_q; addr_n = addr_q; wd_n = wd_q; rdata_n = rdata_q; ack_n = 1'b0;
    unique case (st)
      ST_IDLE: if (req && !ack_q) begin
        st_n   = nonmux ? ST_DAT : ST_ADR;
        cnt_n  = '0;
        half_n = 1'b0;
        area_n = '{bw8: area_bw8, big: area_big, wrx: area_wrx,
                   as_full: area_as_full, ace: area_ace, wcode: area_wait};
        we_n   = we;
        sz_n   = size16;
        addr_n = addr;
        wd_n   = wdata;
      end
      ST_ADR: begin
        if (cnt == CNT_W'(area_q.ace)) begin
          st_n  = ST_DAT;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_DAT: begin
        if (!strobe_ph) cnt_n = cnt + 1'b1;
        if (fin) begin
          if (!we_q) rdata_n = rmerge;
          if (split && !half) begin
            half_n = 1'b1;
            st_n   = nonmux ? ST_DAT : ST_ADR;
            cnt_n  = '0;
          end else begin
            st_n  = ST_IDLE;
            ack_n = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; half <= 1'b0; area_q <= '0; we_q <= 1'b0;
      sz_q <= 1'b0; addr_q <= '0; wd_q <= '0; rdata_q <= '0; ack_q <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; half <= half_n; area_q <= area_n; we_q <= we_n;
      sz_q <= sz_n; addr_q <= addr_n; wd_q <= wd_n; rdata_q <= rdata_n; ack_q <= ack_n;
    end
  end

  // pin outputs, decoded from state only
  always_comb begin
    as_act = (st == ST_ADR && (area_q.as_full || cnt == '0)) ||
             (nonmux && st == ST_DAT && (area_q.as_full || cnt == '0));
  end

  assign as_o   = en_as ? (as_high ? as_act : ~as_act) : ~as_high;
  assign rd_n   = ~(en_rd && st == ST_DAT && !we_q);
  assign wrl_n  = ~(en_wrl && strobe_ph && we_q && wr_lo);
  assign wrh_n  = ~(en_wrh && strobe_ph && we_q && wr_hi);
  assign ub_n   = ~(en_ub && busy && hi_act);
  assign lb_n   = ~(en_lb && busy && lo_act);
  assign ad_oe  = (st == ST_ADR) || (st == ST_DAT && we_q);
  assign ad_out = (st == ST_ADR) ? cyc_addr[15:0] :
                  (st == ST_DAT && we_q) ? wbus : '0;
  assign a_out  = busy ? cyc_addr : '0;
  assign ack    = ack_q;
  assign rdata  = rdata_q;

  // R1
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R1
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (a_out == '0 && !ad_oe));
  // R5
  rd_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  // R6
  wr_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrl_n || !wrh_n) |-> ad_oe);
  // R6
  wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wrl_n) |-> $past(ad_oe));
  // R5
  rd_wr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (wrl_n && wrh_n));
endmodule

// File: tb/xbus_seq_test.sv
`timescale 1ns/1ps
module xbus_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req, we, size16, ack, ad_oe, as_o, rd_n, wrl_n, wrh_n, ub_n, lb_n;
  logic [23:0] addr, a_out;
  logic [15:0] wdata, rdata, ad_in, ad_out;
  logic c_bw8, c_big, c_wrx, c_full, c_ace, c_nonmux, c_ashi, c_rdy_en, rdy_i;
  logic [2:0] c_wcode;
  logic c_en_as, c_en_rd, c_en_wrl, c_en_wrh, c_en_ub, c_en_lb;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  xbus_seq #(.ADDR_W(24)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size16(size16), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata), .area_bw8(c_bw8), .area_big(c_big),
    .area_wrx(c_wrx), .area_as_full(c_full), .area_ace(c_ace), .area_wait(c_wcode),
    .nonmux(c_nonmux), .as_high(c_ashi), .rdy_en(c_rdy_en), .rdy_i(rdy_i),
    .en_as(c_en_as), .en_rd(c_en_rd), .en_wrl(c_en_wrl), .en_wrh(c_en_wrh),
    .en_ub(c_en_ub), .en_lb(c_en_lb), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .a_out(a_out), .as_o(as_o), .rd_n(rd_n), .wrl_n(wrl_n), .wrh_n(wrh_n),
    .ub_n(ub_n), .lb_n(lb_n)
  );

  function automatic int waits(input logic [2:0] c);
    case (c)
      3'd5: return 8;
      3'd6: return 16;
      3'd7: return 32;
      default: return int'(c);
    endcase
  endfunction

  function automatic logic [47:0] pins();
    return {ack, as_o, rd_n, wrl_n, wrh_n, ub_n, lb_n, ad_oe, ad_out, a_out};
  endfunction

  function automatic logic [47:0] idle_v();
    return {1'b0, !c_ashi, 5'b11111, 1'b0, 16'h0, 24'h0};
  endfunction

  function automatic logic [47:0] mk(input logic as_a, rd, wl, wh, ub, lb, oe,
                                     input logic [15:0] ado, input logic [23:0] ao);
    logic asv;
    asv = c_en_as ? (c_ashi ? as_a : !as_a) : !c_ashi;
    return {1'b0, asv, !(rd && c_en_rd), !(wl && c_en_wrl), !(wh && c_en_wrh),
            !(ub && c_en_ub), !(lb && c_en_lb), oe, ado, ao};
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // cycle-by-cycle reference: builds the expected pin timeline, then replays it
  task automatic access(input string tag, input logic wr, input logic s16,
                        input logic [23:0] a, input logic [15:0] wd,
                        input logic [15:0] p0, input logic [15:0] p1, input int lo);
    logic [47:0] eq[$];
    logic rq[$];
    logic [15:0] dq[$];
    logic [15:0] rexp;
    int nb, nset, nd, na;
    rexp = 16'h0;
    nb = (c_bw8 && s16) ? 2 : 1;
    for (int b = 0; b < nb; b++) begin
      logic [23:0] ca;
      logic lo_l, hi_l, hs, stb;
      logic [15:0] wb, p;
      logic [7:0] bt;
      hs = (b == 1) ^ c_big;
      p  = (b == 1) ? p1 : p0;
      ca = (c_bw8 && s16) ? {a[23:1], b[0]} : (s16 ? {a[23:1], 1'b0} : a);
      lo_l = c_bw8 || s16 || !a[0];
      hi_l = !c_bw8 && (s16 || a[0]);
      if (c_bw8)    wb = {8'h0, (s16 && hs) ? wd[15:8] : wd[7:0]};
      else if (s16) wb = c_big ? {wd[7:0], wd[15:8]} : wd;
      else          wb = a[0] ? {wd[7:0], 8'h0} : {8'h0, wd[7:0]};
      na = c_nonmux ? 0 : 1 + int'(c_ace);
      for (int i = 0; i < na; i++) begin
        eq.push_back(mk(c_full || i == 0, 0, 0, 0, hi_l, lo_l, 1, ca[15:0], ca));
        rq.push_back(1'b0); dq.push_back(p);
      end
      nset = 1 + waits(c_wcode);
      nd = nset + (c_rdy_en ? lo + 1 : 1);
      for (int j = 0; j < nd; j++) begin
        stb = wr && (j >= nset);
        eq.push_back(mk(c_nonmux && (c_full || j == 0), !wr, stb && (c_wrx || lo_l),
                        stb && !c_wrx && hi_l, hi_l, lo_l, wr, wr ? wb : 16'h0, ca));
        rq.push_back(c_rdy_en && j == nd - 1); dq.push_back(p);
      end
      if (c_bw8) begin
        bt = p[7:0];
        if (!s16)    rexp = {8'h0, bt};
        else if (hs) rexp[15:8] = bt;
        else         rexp[7:0] = bt;
      end else if (s16) rexp = c_big ? {p[7:0], p[15:8]} : p;
      else rexp = {8'h0, a[0] ? p[15:8] : p[7:0]};
    end
    @(negedge clk);
    req = 1'b1; we = wr; size16 = s16; addr = a; wdata = wd; rdy_i = 1'b0;
    foreach (eq[k]) begin
      @(negedge clk);
      rdy_i = rq[k]; ad_in = dq[k];
      check(tag, pins(), eq[k]);
    end
    @(negedge clk);
    rdy_i = 1'b0;
    check({tag, " R1 ack"}, pins(), idle_v() | (48'h1 << 47));
    req = 1'b0;
    if (!wr) check({tag, " rdata"}, {32'h0, rdata}, {32'h0, rexp});
  endtask

  task automatic base_cfg();
    c_bw8 = 0; c_big = 0; c_wrx = 0; c_full = 0; c_ace = 0; c_wcode = 3'd0;
    c_nonmux = 0; c_ashi = 1; c_rdy_en = 0;
    c_en_as = 1; c_en_rd = 1; c_en_wrl = 1; c_en_wrh = 1; c_en_ub = 1; c_en_lb = 1;
  endtask

  initial begin
    base_cfg();
    req = 0; we = 0; size16 = 0; addr = '0; wdata = '0; ad_in = '0; rdy_i = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 reset", pins(), idle_v());
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 idle", pins(), idle_v());

    // R3 R6 multiplexed word write, little endian, no waits
    access("R3 R6 mux write", 1, 1, 24'h401234, 16'hA55A, 16'h0, 16'h0, 0);
    // R3 R5 multiplexed word read
    access("R3 R5 mux read", 0, 1, 24'h400010, 16'h0, 16'hBEEF, 16'h0, 0);
    // R2 R4 extension, full-time strobe, wait code 5
    c_ace = 1; c_full = 1; c_wcode = 3'd5;
    access("R2 R4 ext read", 0, 1, 24'h123456, 16'h0, 16'h1357, 16'h0, 0);
    // R2 R4 extension, half-time strobe, wait code 7
    c_full = 0; c_wcode = 3'd7;
    access("R2 R4 wait32 write", 1, 1, 24'h00fffe, 16'h2468, 16'h0, 16'h0, 0);
    c_ace = 0;
    // R2 codes 4 and 6
    c_wcode = 3'd4;
    access("R2 wait4 read", 0, 0, 24'h000021, 16'h0, 16'h7788, 16'h0, 0);
    c_wcode = 3'd6;
    access("R2 wait16 write", 1, 0, 24'h000020, 16'h00C3, 16'h0, 16'h0, 0);
    // R3 R4 non-multiplexed, active-low strobe, both schemes
    c_nonmux = 1; c_ashi = 0; c_wcode = 3'd3; c_full = 1;
    access("R3 R4 nonmux read", 0, 1, 24'h800100, 16'h0, 16'hCAFE, 16'h0, 0);
    c_full = 0; c_wcode = 3'd0;
    access("R3 R4 nonmux write", 1, 1, 24'h800102, 16'h0F0F, 16'h0, 16'h0, 0);
    c_nonmux = 0; c_ashi = 1;
    // R7 ready extends, then ready low is ignored when disabled
    c_rdy_en = 1; c_wcode = 3'd1;
    access("R7 ready read", 0, 1, 24'h200000, 16'h0, 16'h4242, 16'h0, 3);
    access("R7 ready write", 1, 1, 24'h200002, 16'h9999, 16'h0, 16'h0, 2);
    c_rdy_en = 0;
    access("R7 ready ignored", 0, 1, 24'h200004, 16'h0, 16'h5151, 16'h0, 4);
    c_wcode = 3'd0;
    // R8 R10 byte lanes on a 16-bit area, separate strobes
    access("R8 R10 odd byte write", 1, 0, 24'h300001, 16'h00AB, 16'h0, 16'h0, 0);
    access("R8 R10 even byte write", 1, 0, 24'h300000, 16'h00CD, 16'h0, 16'h0, 0);
    access("R8 odd byte read", 0, 0, 24'h300003, 16'h0, 16'h6A5B, 16'h0, 0);
    c_big = 1;
    access("R8 big word write", 1, 1, 24'h300004, 16'h1122, 16'h0, 16'h0, 0);
    access("R8 big word read", 0, 1, 24'h300006, 16'h0, 16'h3344, 16'h0, 0);
    c_big = 0;
    // R10 single write strobe
    c_wrx = 1;
    access("R10 single strobe word", 1, 1, 24'h300008, 16'h5566, 16'h0, 16'h0, 0);
    access("R10 single strobe odd", 1, 0, 24'h300009, 16'h0077, 16'h0, 16'h0, 0);
    c_wrx = 0;
    // R9 8-bit area splitting, both byte orders
    c_bw8 = 1; c_wcode = 3'd2;
    access("R9 le word read", 0, 1, 24'h500010, 16'h0, 16'h0012, 16'h0034, 0);
    c_big = 1;
    access("R9 be word read", 0, 1, 24'h500012, 16'h0, 16'h0056, 16'h0078, 0);
    access("R9 be word write", 1, 1, 24'h500014, 16'h9ABC, 16'h0, 16'h0, 0);
    c_big = 0; c_nonmux = 1;
    access("R9 le nonmux write", 1, 1, 24'h500016, 16'hDEF0, 16'h0, 16'h0, 0);
    access("R9 byte read", 0, 0, 24'h500019, 16'h0, 16'h00E1, 16'h0, 0);
    c_nonmux = 0; c_bw8 = 0; c_wcode = 3'd0;
    // R11 strobe enables held inactive
    c_en_as = 0; c_en_wrl = 0; c_en_ub = 0;
    access("R11 disabled write", 1, 1, 24'h600000, 16'h0BAD, 16'h0, 16'h0, 0);
    c_en_as = 1; c_en_wrl = 1; c_en_ub = 1; c_en_rd = 0; c_en_lb = 0; c_ashi = 0;
    access("R11 disabled read", 0, 1, 24'h600002, 16'h0, 16'hF00D, 16'h0, 0);
    base_cfg();
    @(negedge clk);
    check("R1 back to idle", pins(), idle_v());

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule